// File: doc/BRIEF.md
# Software-Managed Translation Buffer Maintenance Unit

This block holds a small fully associative translation buffer whose contents are managed entirely by privileged software. It does not translate addresses. It carries out the four maintenance operations that a system-control coprocessor issues: probe, indexed read, indexed write and random write. The coprocessor places its current page-table register values on input ports together with an operation code. One cycle later the block returns the updated register values on output ports and pulses a completion flag.

Each entry maps a pair of adjacent virtual pages, one even and one odd. Each half has its own physical frame, valid, dirty and cache-attribute fields. The entry also has one shared tag: a virtual page number, an address-space identifier, a page-size mask and a global flag. The global flag is set only when both halves mark themselves global. A free-running replacement counter picks the slot for random writes. It counts down and never goes below a software-set floor, so that the slots under the floor stay reserved.

Top module: `tlb_maint`

## Requirements
- R1: While reset is held and in the first cycle after it, `op_done` is 0, `rand_idx` is 15 and all result outputs are zero. Every entry is invalid, so a probe issued straight after reset misses.
- R2: An operation is taken when `op_valid` is 1 at a rising clock edge. `op_done` is 1 in the cycle after that edge. For an isolated request it is 1 for exactly one cycle. The operation codes are 0 probe, 1 indexed read, 2 indexed write and 3 random write.
- R3: An indexed write fills the entry selected by `idx_in[3:0]`. It stores the page number `hi_in[31:13]`, the address-space tag `hi_in[7:0]` and the size field `mask_in[24:13]`. For each half it stores V (bit 1), D (bit 2), the cache attribute (bits 5:3) and the frame number (bits 31:6). The global flag stored is `lo0_in[0] & lo1_in[0]`. The entry becomes valid.
- R4: An indexed read of entry `idx_in[3:0]` returns three values. `hi_out` carries the page number in bits 31:13 and the tag in bits 7:0, with bits 12:8 zero. Each `loN_out` carries the stored bits 31:1 of its half, with bit 0 zero. `mask_out` carries the size field in bits 24:13 and zeros elsewhere.
- R5: A probe that hits writes the lowest matching slot number to `idx_out`, zero-extended, with bit 31 clear.
- R6: An entry matches a probe when it is valid, `hi_in[31:13]` equals its page number, and either its global flag is set or `hi_in[7:0]` equals its tag. Bits 12:8 of `hi_in` have no effect on the match.
- R7: A probe that misses returns `idx_in` with bit 31 set and every other bit unchanged.
- R8: `rand_idx` counts down by one each cycle. When its value is less than or equal to `wired_in` at a clock edge, it goes back to 15 at that edge.
- R9: A random write fills the slot shown on `rand_idx` in the cycle the request is taken, and ignores `idx_in`.
- R10: Every result output that an operation does not produce is a copy of the matching input. A probe and a write return `hi_in`, `lo0_in`, `lo1_in` and `mask_in` as they were. A read and a write return `idx_in`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Request strobe |
| op_code | input | 2 | 0 probe, 1 indexed read, 2 indexed write, 3 random write |
| idx_in | input | 32 | Index register value |
| hi_in | input | 32 | Page number and address-space tag |
| lo0_in | input | 32 | Even-page mapping |
| lo1_in | input | 32 | Odd-page mapping |
| mask_in | input | 32 | Page-size mask |
| wired_in | input | 4 | Floor for the replacement counter |
| op_done | output | 1 | One-cycle completion flag |
| idx_out | output | 32 | Updated index register value |
| hi_out | output | 32 | Updated page number and tag |
| lo0_out | output | 32 | Updated even-page mapping |
| lo1_out | output | 32 | Updated odd-page mapping |
| mask_out | output | 32 | Updated page-size mask |
| rand_idx | output | 4 | Current replacement slot |

## Verification
Every operation result and `op_done` is due one clock edge after the edge that takes the request. The bench drives a request on a falling edge, lets one rising edge take it, and reads the results at the next falling edge. One more falling edge later it confirms that `op_done` has dropped. The replacement counter moves at every rising edge. The bench samples it at each falling edge and predicts the next value from the previous sample and the `wired_in` value that was present at the edge in between. The slot used by a random write is the value sampled just before the edge that takes the request.

// File: rtl/tlb_maint.sv
`timescale 1ns/1ps
module tlb_maint #(
  parameter int ENTRIES = 16,
  parameter int RW      = 32
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        op_valid,
  input  logic [1:0]                  op_code,
  input  logic [RW-1:0]               idx_in,
  input  logic [RW-1:0]               hi_in,
  input  logic [RW-1:0]               lo0_in,
  input  logic [RW-1:0]               lo1_in,
  input  logic [RW-1:0]               mask_in,
  input  logic [$clog2(ENTRIES)-1:0]  wired_in,
  output logic                        op_done,
  output logic [RW-1:0]               idx_out,
  output logic [RW-1:0]               hi_out,
  output logic [RW-1:0]               lo0_out,
  output logic [RW-1:0]               lo1_out,
  output logic [RW-1:0]               mask_out,
  output logic [$clog2(ENTRIES)-1:0]  rand_idx
);
  localparam int IW  = $clog2(ENTRIES);
  localparam int VW  = RW - 13;
  localparam int MW  = 12;
  localparam logic [IW-1:0] TOP = IW'(ENTRIES - 1);
  localparam logic [1:0] OP_PROBE = 2'd0;
  localparam logic [1:0] OP_READ  = 2'd1;
  localparam logic [1:0] OP_WIDX  = 2'd2;
  localparam logic [1:0] OP_WRND  = 2'd3;

  logic [VW-1:0]   vpn_q  [ENTRIES];
  logic [7:0]      asid_q [ENTRIES];
  logic [MW-1:0]   mask_q [ENTRIES];
  logic [RW-2:0]   lo0_q  [ENTRIES];
  logic [RW-2:0]   lo1_q  [ENTRIES];
  logic [ENTRIES-1:0] glob_q, valid_q;
  logic [IW-1:0]   rnd_q;

  logic            hit;
  logic [IW-1:0]   hit_idx;
  logic [IW-1:0]   ridx, widx;
  logic            wen;

  assign rand_idx = rnd_q;
  assign ridx     = idx_in[IW-1:0];
  assign widx     = (op_code == OP_WRND) ? rnd_q : idx_in[IW-1:0];
  assign wen      = op_valid && op_code[1];

  always_comb begin
    hit     = 1'b0;
    hit_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (valid_q[i] && vpn_q[i] == hi_in[RW-1:13] &&
          (glob_q[i] || asid_q[i] == hi_in[7:0])) begin
        hit     = 1'b1;
        hit_idx = IW'(i);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q  <= '0;
      glob_q   <= '0;
      rnd_q    <= TOP;
      op_done  <= 1'b0;
      idx_out  <= '0;
      hi_out   <= '0;
      lo0_out  <= '0;
      lo1_out  <= '0;
      mask_out <= '0;
      for (int i = 0; i < ENTRIES; i++) begin
        vpn_q[i]  <= '0;
        asid_q[i] <= '0;
        mask_q[i] <= '0;
        lo0_q[i]  <= '0;
        lo1_q[i]  <= '0;
      end
    end else begin
      rnd_q   <= (rnd_q <= wired_in) ? TOP : rnd_q - 1'b1;
      op_done <= op_valid;
      if (wen) begin
        vpn_q[widx]   <= hi_in[RW-1:13];
        asid_q[widx]  <= hi_in[7:0];
        mask_q[widx]  <= mask_in[13+MW-1:13];
        lo0_q[widx]   <= lo0_in[RW-1:1];
        lo1_q[widx]   <= lo1_in[RW-1:1];
        glob_q[widx]  <= lo0_in[0] & lo1_in[0];
        valid_q[widx] <= 1'b1;
      end
      if (op_valid) begin
        idx_out  <= idx_in;
        hi_out   <= hi_in;
        lo0_out  <= lo0_in;
        lo1_out  <= lo1_in;
        mask_out <= mask_in;
        case (op_code)
          OP_PROBE: idx_out <= hit ? RW'(hit_idx) : (idx_in | (RW'(1) << (RW-1)));
          OP_READ: begin
            hi_out   <= {vpn_q[ridx], 5'b0, asid_q[ridx]};
            lo0_out  <= {lo0_q[ridx], 1'b0};
            lo1_out  <= {lo1_q[ridx], 1'b0};
            mask_out <= RW'({mask_q[ridx], 13'b0});
          end
          default: ;
        endcase
      end
    end
  end

  assert_miss_keeps_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (op_done && $past(op_code) == OP_PROBE && idx_out[RW-1])
      |-> idx_out[RW-2:0] == $past(idx_in[RW-2:0]));

  assert_hit_clean_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (op_done && $past(op_code) == OP_PROBE && !idx_out[RW-1])
      |-> idx_out[RW-2:IW] == '0);

  assert_write_valid_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (op_done && $past(op_code) == OP_WIDX) |-> valid_q[$past(idx_in[IW-1:0])]);

  assert_rand_wrap_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(rnd_q) <= $past(wired_in)) |-> rnd_q == TOP);

  assert_done_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(op_valid)) |-> !op_done);
endmodule

// File: tb/sim_tlb_maint.sv
`timescale 1ns/1ps
module sim_tlb_maint;
  logic clk = 1'b0, rst_n = 1'b0, op_valid = 1'b0;
  logic [1:0] op_code = 2'd0;
  logic [31:0] idx_in = 0, hi_in = 0, lo0_in = 0, lo1_in = 0, mask_in = 0;
  logic [3:0] wired_in = 4'd0;
  logic op_done;
  logic [31:0] idx_out, hi_out, lo0_out, lo1_out, mask_out;
  logic [3:0] rand_idx;
  int tests = 0, fails = 0;
  bit finished = 1'b0;
  logic [3:0] rnd_seen;

  logic [31:0] m_hi [16], m_lo0 [16], m_lo1 [16], m_pm [16];
  logic [15:0] m_val = '0, m_g = '0;

  always #10 clk = ~clk;

  tlb_maint u0 (.clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
    .idx_in(idx_in), .hi_in(hi_in), .lo0_in(lo0_in), .lo1_in(lo1_in), .mask_in(mask_in),
    .wired_in(wired_in), .op_done(op_done), .idx_out(idx_out), .hi_out(hi_out),
    .lo0_out(lo0_out), .lo1_out(lo1_out), .mask_out(mask_out), .rand_idx(rand_idx));

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic op(input logic [1:0] c, input logic [31:0] ix, hi, l0, l1, pm);
    @(negedge clk);
    op_valid = 1'b1; op_code = c; idx_in = ix; hi_in = hi; lo0_in = l0; lo1_in = l1; mask_in = pm;
    rnd_seen = rand_idx;
    @(negedge clk);
    op_valid = 1'b0;
    chk(op_done === 1'b1, "R2 done", 32'(op_done), 32'd1);
  endtask

  task automatic done_drop;
    @(negedge clk);
    chk(op_done === 1'b0, "R2 pulse", 32'(op_done), 32'd0);
  endtask

  task automatic model_write(input int k, input logic [31:0] hi, l0, l1, pm);
    m_hi[k]  = {hi[31:13], 5'b0, hi[7:0]};
    m_lo0[k] = {l0[31:1], 1'b0};
    m_lo1[k] = {l1[31:1], 1'b0};
    m_pm[k]  = {7'b0, pm[24:13], 13'b0};
    m_g[k]   = l0[0] & l1[0];
    m_val[k] = 1'b1;
  endtask

  function automatic logic [31:0] exp_probe(input logic [31:0] hi, input logic [31:0] ix);
    for (int i = 0; i < 16; i++)
      if (m_val[i] && m_hi[i][31:13] == hi[31:13] && (m_g[i] || m_hi[i][7:0] == hi[7:0]))
        return 32'(i);
    return ix | 32'h8000_0000;
  endfunction

  task automatic probe_chk(input logic [31:0] hi, input logic [31:0] ix, input string req);
    logic [31:0] e;
    e = exp_probe(hi, ix);
    op(2'd0, ix, hi, 32'h1234_5678, 32'h9ABC_DEF0, 32'h0F0F_0F0F);
    chk(idx_out === e, req, idx_out, e);
    chk(hi_out === hi && lo0_out === 32'h1234_5678 && mask_out === 32'h0F0F_0F0F,
        "R10 probe passthru", hi_out, hi);
  endtask

  task automatic read_chk(input int k);
    op(2'd1, 32'(k) | 32'h0000_0A30, 32'hFFFF_FFFF, 32'h0, 32'h0, 32'h0);
    chk(hi_out === m_hi[k], "R4 hi", hi_out, m_hi[k]);
    chk(lo0_out === m_lo0[k], "R4 lo0", lo0_out, m_lo0[k]);
    chk(lo1_out === m_lo1[k], "R4 lo1", lo1_out, m_lo1[k]);
    chk(mask_out === m_pm[k], "R4 mask", mask_out, m_pm[k]);
    chk(idx_out === (32'(k) | 32'h0000_0A30), "R10 read idx", idx_out, 32'(k) | 32'h0000_0A30);
  endtask

  function automatic logic [31:0] pat_hi(input int i);
    return {19'(i * 24593 + 5), 5'(i), 8'(i * 29 + 3)};
  endfunction
  function automatic logic [31:0] pat_lo(input int i, input int s, input bit g);
    return {26'(i * 77777 + s * 5003 + 1), 3'(i + s), 1'(i), 1'(i >> 1), g};
  endfunction

  initial begin
    #3000000;
    if (!finished) begin
      fails++; tests++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [3:0] prev, expn;
    logic [31:0] h, l0, l1, pm;
    repeat (3) @(negedge clk);
    chk(op_done === 1'b0 && rand_idx === 4'd15 && idx_out === 0 && hi_out === 0,
        "R1 reset", 32'(rand_idx), 32'd15);
    rst_n = 1'b1;
    @(negedge clk);
    chk(rand_idx === 4'd14, "R8 first count", 32'(rand_idx), 32'd14);
    probe_chk(32'h0000_2000, 32'h0000_0003, "R1 empty probe misses");
    done_drop();

    for (int w = 0; w < 16; w++) begin
      wired_in = 4'(w);
      prev = rand_idx;
      for (int c = 0; c < 40; c++) begin
        @(negedge clk);
        expn = (prev <= 4'(w)) ? 4'd15 : prev - 4'd1;
        chk(rand_idx === expn, "R8 counter", 32'(rand_idx), 32'(expn));
        prev = rand_idx;
      end
    end
    wired_in = 4'd0;

    for (int i = 0; i < 16; i++) begin
      h  = pat_hi(i);
      l0 = pat_lo(i, 0, (i % 4) <= 1);
      l1 = pat_lo(i, 1, (i % 4) == 0);
      pm = 32'(i) * 32'h0123_4567;
      op(2'd2, 32'(i) | 32'h0000_0150, h, l0, l1, pm);
      model_write(i, h, l0, l1, pm);
      chk(hi_out === h && idx_out === (32'(i) | 32'h150), "R10 write passthru", hi_out, h);
    end
    done_drop();
    for (int i = 0; i < 16; i++) read_chk(i);

    for (int i = 0; i < 16; i++)
      probe_chk(pat_hi(i) ^ 32'h0000_1F00, 32'h0000_0007, "R5 R6 probe hit");
    for (int i = 0; i < 16; i++)
      probe_chk(pat_hi(i) ^ 32'h0000_0040, 32'h0000_00A5, "R6 R7 asid mismatch");
    probe_chk(32'hFFFF_E000, 32'h7000_0005, "R7 page miss");

    h = pat_hi(2);
    op(2'd2, 32'd11, h, 32'h4, 32'h2, 32'h0);
    model_write(11, h, 32'h4, 32'h2, 32'h0);
    op(2'd2, 32'd2, pat_hi(3), 32'h6, 32'h6, 32'h0);
    model_write(2, pat_hi(3), 32'h6, 32'h6, 32'h0);
    probe_chk(pat_hi(3), 32'h0, "R5 lowest of duplicates");
    probe_chk(h, 32'h0, "R5 second copy");

    wired_in = 4'd8;
    repeat (20) @(negedge clk);
    for (int k = 0; k < 6; k++) begin
      h = {19'(k * 999 + 70000), 5'b0, 8'(k + 200)};
      op(2'd3, 32'd1, h, 32'h0000_0102, 32'h0000_0204, 32'h0000_2000);
      chk(rnd_seen >= 4'd8, "R8 floor", 32'(rnd_seen), 32'd8);
      model_write(int'(rnd_seen), h, 32'h0000_0102, 32'h0000_0204, 32'h0000_2000);
      read_chk(int'(rnd_seen));
      probe_chk(h, 32'h0, "R9 random slot");
      read_chk(1);
      repeat (k + 1) @(negedge clk);
    end
    wired_in = 4'd0;

    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule